// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer. It measures time against a shared 64-bit free-running system counter that it receives as an input. Software arms it through a control register window, and it has to keep servicing it. If software misses a deadline, the block first raises an alert output. If it then misses a second deadline of the same length, it raises a reset-request output. Each deadline is an absolute compare value that the block holds internally. The remaining time in the current stage is the compare value minus the system counter. The alert output is meant for an interrupt controller, and the reset request is meant for the reset circuitry.

Two independent 32-bit write/read ports serve the block. The kick port holds only the service register. The control port holds the control/status word, the timeout offset, the compare value and an identification word. A parameter picks the implementation version. Version 0 has a 32-bit offset. Version 1 widens the offset to 48 bits, and its upper 16 bits sit in a second word.

The block has two resets. A power-on reset clears everything. A warm reset, which is the reset the watchdog itself causes, clears everything except the reset-request status flag. Software can therefore tell afterwards that the watchdog caused the restart.

Top module: `twostage_wdt`

## Requirements
- R1: After power-on reset, the control word (0x000), the offset (0x008, 0x00C) and the compare value (0x010, 0x014) all read 0, and both the alert and the reset-request outputs are 0.
- R2: Suppose the block is enabled and the alert flag is clear. In the first cycle in which the system counter is greater than or equal to the compare value, the alert flag sets on the next clock edge. On that same edge, the compare value reloads to counter plus offset.
- R3: Suppose the block is enabled and the alert flag is already set. When the counter again reaches or passes the compare value, the reset-request flag sets on the next edge, and the compare value is left unchanged.
- R4: The control word is at 0x000. Bit 0 is the enable and can be read and written. Bit 1 is the alert flag and bit 2 is the reset-request flag; both are read-only. Any write to this word is a kick. Writing a value whose bit 0 is 0 clears the enable.
- R5: A write of any value to kick-port address 0x000 is a kick. Writes to any other kick-port address have no effect.
- R6: On a kick, the compare value becomes the counter plus the offset, using the offset as it stands after that cycle's write. A kick also clears both flags. A kick takes priority over an expiry or a compare write in the same cycle.
- R7: The low 32 offset bits are at 0x008. In version 1, bits 47:32 of the offset are at bits 15:0 of 0x00C, and bits 31:16 of that word read 0. In version 0, 0x00C reads 0 and writes to it are ignored. An offset write is a kick only while the block is enabled.
- R8: The compare value is at 0x010 (low word) and 0x014 (high word). It can be written directly, and such a write is not a kick. A compare write suppresses expiry evaluation for its cycle.
- R9: The identification word at 0xFCC holds the version in bits 19:16, with all other bits 0, so version 1 reads 0x00010000. Unmapped addresses read 0.
- R10: While the enable is 0, neither flag newly sets, however far the counter passes the compare value.
- R11: The alert output and the reset-request output are levels equal to control-word bits 1 and 2.
- R12: A warm reset clears the enable, the alert flag, the offset and the compare value, but leaves the reset-request flag and its output as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Synchronous power-on reset, active high, clears all state |
| rst | input | 1 | Synchronous warm reset, active high, keeps the reset-request flag |
| sys_cnt | input | 64 | Free-running system counter value |
| rf_wr_en | input | 1 | Kick port write strobe |
| rf_addr | input | 12 | Kick port byte address |
| cf_wr_en | input | 1 | Control port write strobe |
| cf_addr | input | 12 | Control port byte address, also selects the read word |
| cf_wdata | input | 32 | Control port write data |
| cf_rdata | output | 32 | Control port read data, combinational from cf_addr |
| ws0 | output | 1 | Alert output (first-stage expiry) |
| ws1 | output | 1 | Reset-request output (second-stage expiry) |

## Verification
The hardest case to reach from the ports is a collision: a kick landing in the very cycle that the counter crosses the compare value, or a kick arriving alongside a direct compare write. The bench forces one such collision by writing a compare value in the past on the control port while kicking on the kick port in the same cycle. A long seeded random phase adds more collisions. It uses small offsets and uneven counter steps, so that expiries and kicks fall on top of each other many times. A reference model in the bench tracks the expected compare value and flags on every edge.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int VER_LSB = 16;

    localparam logic [ADDR_W-1:0] A_KICK   = 12'h000;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] A_OFS_LO = 12'h008;
    localparam logic [ADDR_W-1:0] A_OFS_HI = 12'h00C;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h010;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h014;
    localparam logic [ADDR_W-1:0] A_IDENT  = 12'hFCC;

    typedef struct packed {
        logic ctrl;
        logic ofs_lo;
        logic ofs_hi;
        logic cmp_lo;
        logic cmp_hi;
    } wstrobe_t;

    typedef struct packed {
        logic st1;
        logic st0;
        logic en;
    } ctrl_word_t;

    function automatic int ofs_width(input int ver);
        return (ver == 0) ? 32 : 48;
    endfunction

    function automatic logic [DATA_W-1:0] ident_word(input int ver);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VER_LSB +: 4] = 4'(ver);
        return w;
    endfunction
endpackage

// File: rtl/wdg_kick_decode.sv
`timescale 1ns/1ps
module wdg_kick_decode
    import wdg_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              kick
);
    always_comb begin
        kick = wr_en && (addr == A_KICK);
    end
endmodule

// File: rtl/wdg_ctrl_decode.sv
`timescale 1ns/1ps
module wdg_ctrl_decode
    import wdg_pkg::*;
#(
    parameter int VERSION = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              enable_q,
    input  logic              ext_kick,
    output wstrobe_t          stb,
    output logic              refresh
);
    logic hi_hit;

    generate
        if (VERSION == 0) begin : g_narrow
            assign hi_hit = 1'b0;
        end else begin : g_wide
            assign hi_hit = wr_en && (addr == A_OFS_HI);
        end
    endgenerate

    always_comb begin
        stb.ctrl   = wr_en && (addr == A_CTRL);
        stb.ofs_lo = wr_en && (addr == A_OFS_LO);
        stb.ofs_hi = hi_hit;
        stb.cmp_lo = wr_en && (addr == A_CMP_LO);
        stb.cmp_hi = wr_en && (addr == A_CMP_HI);
        refresh    = ext_kick || stb.ctrl ||
                     (enable_q && (stb.ofs_lo || stb.ofs_hi));
    end
endmodule

// File: rtl/wdg_cfg_regs.sv
`timescale 1ns/1ps
module wdg_cfg_regs
    import wdg_pkg::*;
#(
    parameter int OFS_W = 48
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              ctrl_wr,
    input  logic              ofs_lo_wr,
    input  logic              ofs_hi_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              enable_q,
    output logic [OFS_W-1:0]  offset_q,
    output logic [OFS_W-1:0]  offset_d
);
    localparam int HI_W = OFS_W - DATA_W;

    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] lo_d;

    always_comb begin
        lo_d = ofs_lo_wr ? wdata : lo_q;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            enable_q <= 1'b0;
            lo_q     <= '0;
        end else begin
            if (ctrl_wr) enable_q <= wdata[0];
            lo_q <= lo_d;
        end
    end

    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] hi_q;
            logic [HI_W-1:0] hi_d;
            always_comb begin
                hi_d = ofs_hi_wr ? wdata[HI_W-1:0] : hi_q;
            end
            always_ff @(posedge clk) begin
                if (clr) hi_q <= '0;
                else     hi_q <= hi_d;
            end
            assign offset_q = {hi_q, lo_q};
            assign offset_d = {hi_d, lo_d};
        end else begin : g_lo_only
            logic unused_hi;
            assign unused_hi = ofs_hi_wr;
            assign offset_q = lo_q;
            assign offset_d = lo_d;
        end
    endgenerate

    // R4: a control write with bit 0 low leaves the watchdog stopped
    p_stop_on_zero_r4: assert property (@(posedge clk)
        (!clr && ctrl_wr && !wdata[0]) |=> !enable_q);
endmodule

// File: rtl/wdg_stage_engine.sv
`timescale 1ns/1ps
module wdg_stage_engine
    import wdg_pkg::*;
#(
    parameter int OFS_W = 48
) (
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              enable_q,
    input  logic              refresh,
    input  logic              cmp_lo_wr,
    input  logic              cmp_hi_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFS_W-1:0]  offset_d,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              st0_q,
    output logic              st1_q
);
    logic [CNT_W-1:0] deadline;
    logic             expired;

    always_comb begin
        deadline = sys_cnt + CNT_W'(offset_d);
        expired  = enable_q && (sys_cnt >= cmp_q);
    end

    always_ff @(posedge clk) begin
        if (rst_por) begin
            cmp_q <= '0;
            st0_q <= 1'b0;
            st1_q <= 1'b0;
        end else if (rst) begin
            cmp_q <= '0;
            st0_q <= 1'b0;
        end else if (refresh) begin
            cmp_q <= deadline;
            st0_q <= 1'b0;
            st1_q <= 1'b0;
        end else if (cmp_lo_wr) begin
            cmp_q[DATA_W-1:0] <= wdata;
        end else if (cmp_hi_wr) begin
            cmp_q[CNT_W-1:DATA_W] <= wdata;
        end else if (expired) begin
            if (!st0_q) begin
                st0_q <= 1'b1;
                cmp_q <= deadline;
            end else begin
                st1_q <= 1'b1;
            end
        end
    end

    // R2: the alert only rises after an enabled deadline was reached
    p_alert_needs_deadline_r2: assert property (@(posedge clk) disable iff (rst_por)
        $rose(st0_q) |-> $past(enable_q && (sys_cnt >= cmp_q)));

    // R3: the reset request is only reached through the alert stage
    p_reset_after_alert_r3: assert property (@(posedge clk) disable iff (rst_por)
        $rose(st1_q) |-> $past(st0_q));

    // R6: a kick leaves both stage flags clear
    p_kick_clears_r6: assert property (@(posedge clk) disable iff (rst_por)
        (refresh && !rst) |=> (!st0_q && !st1_q));

    // R10: nothing newly fires while stopped
    p_quiet_when_stopped_r10: assert property (@(posedge clk) disable iff (rst_por)
        !enable_q |=> (!$rose(st0_q) && !$rose(st1_q)));
endmodule

// File: rtl/twostage_wdt.sv
`timescale 1ns/1ps
module twostage_wdt
    import wdg_pkg::*;
#(
    parameter int VERSION = 1
) (
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              rf_wr_en,
    input  logic [ADDR_W-1:0] rf_addr,
    input  logic              cf_wr_en,
    input  logic [ADDR_W-1:0] cf_addr,
    input  logic [DATA_W-1:0] cf_wdata,
    output logic [DATA_W-1:0] cf_rdata,
    output logic              ws0,
    output logic              ws1
);
    localparam int OFS_W = ofs_width(VERSION);

    logic             kick;
    logic             refresh;
    wstrobe_t         stb;
    logic             enable_q;
    logic [OFS_W-1:0] offset_q;
    logic [OFS_W-1:0] offset_d;
    logic [CNT_W-1:0] cmp_q;
    logic             st0_q;
    logic             st1_q;
    logic [DATA_W-1:0] ofs_hi_word;
    ctrl_word_t       cw;

    wdg_kick_decode u_kick (
        .wr_en (rf_wr_en),
        .addr  (rf_addr),
        .kick  (kick)
    );

    wdg_ctrl_decode #(.VERSION(VERSION)) u_dec (
        .wr_en    (cf_wr_en),
        .addr     (cf_addr),
        .enable_q (enable_q),
        .ext_kick (kick),
        .stb      (stb),
        .refresh  (refresh)
    );

    wdg_cfg_regs #(.OFS_W(OFS_W)) u_cfg (
        .clk       (clk),
        .clr       (rst_por || rst),
        .ctrl_wr   (stb.ctrl),
        .ofs_lo_wr (stb.ofs_lo),
        .ofs_hi_wr (stb.ofs_hi),
        .wdata     (cf_wdata),
        .enable_q  (enable_q),
        .offset_q  (offset_q),
        .offset_d  (offset_d)
    );

    wdg_stage_engine #(.OFS_W(OFS_W)) u_eng (
        .clk       (clk),
        .rst_por   (rst_por),
        .rst       (rst),
        .sys_cnt   (sys_cnt),
        .enable_q  (enable_q),
        .refresh   (refresh),
        .cmp_lo_wr (stb.cmp_lo),
        .cmp_hi_wr (stb.cmp_hi),
        .wdata     (cf_wdata),
        .offset_d  (offset_d),
        .cmp_q     (cmp_q),
        .st0_q     (st0_q),
        .st1_q     (st1_q)
    );

    generate
        if (OFS_W > DATA_W) begin : g_hi_rd
            assign ofs_hi_word = DATA_W'(offset_q[OFS_W-1:DATA_W]);
        end else begin : g_hi_zero
            assign ofs_hi_word = '0;
        end
    endgenerate

    always_comb begin
        cw.st1 = st1_q;
        cw.st0 = st0_q;
        cw.en  = enable_q;
        case (cf_addr)
            A_CTRL:   cf_rdata = DATA_W'(cw);
            A_OFS_LO: cf_rdata = offset_q[DATA_W-1:0];
            A_OFS_HI: cf_rdata = ofs_hi_word;
            A_CMP_LO: cf_rdata = cmp_q[DATA_W-1:0];
            A_CMP_HI: cf_rdata = cmp_q[CNT_W-1:DATA_W];
            A_IDENT:  cf_rdata = ident_word(VERSION);
            default:  cf_rdata = '0;
        endcase
    end

    assign ws0 = st0_q;
    assign ws1 = st1_q;
endmodule

// File: tb/twostage_wdt_test.sv
`timescale 1ns/1ps
module twostage_wdt_test;
    logic        clk = 1'b0;
    logic        rst_por = 1'b1;
    logic        rst = 1'b0;
    logic [63:0] sys_cnt = 64'h1000;
    logic [63:0] step = 64'd1;
    logic        rf_wr_en = 1'b0;
    logic [11:0] rf_addr = 12'h0;
    logic        cf_wr_en = 1'b0;
    logic [11:0] cf_addr = 12'h0;
    logic [31:0] cf_wdata = 32'h0;
    logic [31:0] cf_rdata;
    logic        ws0, ws1;
    logic        v0_wr_en = 1'b0;
    logic [11:0] v0_addr = 12'h0;
    logic [31:0] v0_wdata = 32'h0;
    logic [31:0] v0_rdata;
    logic        v0_ws0, v0_ws1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic mon_on = 1'b0;

    logic        m_en = 1'b0, m_ws0 = 1'b0, m_ws1 = 1'b0;
    logic [47:0] m_ofs = '0;
    logic [63:0] m_cmp = '0;

    always #2.5 clk = ~clk;

    twostage_wdt #(.VERSION(1)) uut (
        .clk(clk), .rst_por(rst_por), .rst(rst), .sys_cnt(sys_cnt),
        .rf_wr_en(rf_wr_en), .rf_addr(rf_addr),
        .cf_wr_en(cf_wr_en), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
        .cf_rdata(cf_rdata), .ws0(ws0), .ws1(ws1)
    );

    twostage_wdt #(.VERSION(0)) uut_v0 (
        .clk(clk), .rst_por(rst_por), .rst(rst), .sys_cnt(sys_cnt),
        .rf_wr_en(1'b0), .rf_addr(12'h0),
        .cf_wr_en(v0_wr_en), .cf_addr(v0_addr), .cf_wdata(v0_wdata),
        .cf_rdata(v0_rdata), .ws0(v0_ws0), .ws1(v0_ws1)
    );

    always @(negedge clk) sys_cnt <= sys_cnt + step;

    // reference model of the requirements (version 1)
    always @(posedge clk) begin
        logic kick_m;
        logic old_en;
        logic [47:0] ofs_n;
        if (rst_por) begin
            m_en = 0; m_ofs = '0; m_cmp = '0; m_ws0 = 0; m_ws1 = 0;
        end else if (rst) begin
            m_en = 0; m_ofs = '0; m_cmp = '0; m_ws0 = 0;
        end else begin
            old_en = m_en;
            ofs_n = m_ofs;
            if (cf_wr_en && cf_addr == 12'h008) ofs_n[31:0] = cf_wdata;
            if (cf_wr_en && cf_addr == 12'h00C) ofs_n[47:32] = cf_wdata[15:0];
            kick_m = (rf_wr_en && rf_addr == 12'h000) ||
                     (cf_wr_en && cf_addr == 12'h000) ||
                     (old_en && cf_wr_en && (cf_addr == 12'h008 || cf_addr == 12'h00C));
            if (cf_wr_en && cf_addr == 12'h000) m_en = cf_wdata[0];
            m_ofs = ofs_n;
            if (kick_m) begin
                m_cmp = sys_cnt + {16'h0, ofs_n}; m_ws0 = 0; m_ws1 = 0;
            end else if (cf_wr_en && cf_addr == 12'h010) begin
                m_cmp[31:0] = cf_wdata;
            end else if (cf_wr_en && cf_addr == 12'h014) begin
                m_cmp[63:32] = cf_wdata;
            end else if (old_en && sys_cnt >= m_cmp) begin
                if (!m_ws0) begin
                    m_ws0 = 1; m_cmp = sys_cnt + {16'h0, ofs_n};
                end else begin
                    m_ws1 = 1;
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return {29'h0, m_ws1, m_ws0, m_en};
            12'h008: return m_ofs[31:0];
            12'h00C: return {16'h0, m_ofs[47:32]};
            12'h010: return m_cmp[31:0];
            12'h014: return m_cmp[63:32];
            12'hFCC: return 32'h0001_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R11: outputs follow the model flags every cycle
    always @(negedge clk) begin
        if (mon_on) begin
            check("R11 ws0 level", {63'h0, ws0}, {63'h0, m_ws0});
            check("R11 ws1 level", {63'h0, ws1}, {63'h0, m_ws1});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cf_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cf_wr_en = 1'b1; cf_addr = a; cf_wdata = d;
        @(posedge clk); #1;
        cf_wr_en = 1'b0;
    endtask

    task automatic rf_write(input logic [11:0] a);
        @(negedge clk);
        rf_wr_en = 1'b1; rf_addr = a;
        @(posedge clk); #1;
        rf_wr_en = 1'b0;
    endtask

    task automatic cf_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        cf_addr = a; #1;
        check(tag, {32'h0, cf_rdata}, {32'h0, exp});
    endtask

    task automatic cf_check_model(input string tag, input logic [11:0] a);
        @(negedge clk);
        cf_addr = a; #1;
        check(tag, {32'h0, cf_rdata}, {32'h0, m_read(a)});
    endtask

    task automatic v0_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        v0_wr_en = 1'b1; v0_addr = a; v0_wdata = d;
        @(posedge clk); #1;
        v0_wr_en = 1'b0;
    endtask

    task automatic v0_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        v0_addr = a; #1;
        check(tag, {32'h0, v0_rdata}, {32'h0, exp});
    endtask

    task automatic wait_stage(input bit second, input int limit, input string tag);
        int n = 0;
        while (((second ? ws1 : ws0) !== 1'b1) && n < limit) begin
            @(negedge clk); #1;
            n++;
        end
        check(tag, {63'h0, (second ? ws1 : ws0)}, 64'h1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        idle(3);
        @(negedge clk);
        rst_por = 1'b0;
        mon_on = 1'b1;

        // R1: power-on state
        cf_check("R1 ctrl after por", 12'h000, 32'h0);
        cf_check("R1 offset lo after por", 12'h008, 32'h0);
        cf_check("R1 offset hi after por", 12'h00C, 32'h0);
        cf_check("R1 compare lo after por", 12'h010, 32'h0);
        cf_check("R1 compare hi after por", 12'h014, 32'h0);

        // R9: identification and unmapped reads
        cf_check("R9 ident version 1", 12'hFCC, 32'h0001_0000);
        cf_check("R9 unmapped reads zero", 12'h100, 32'h0);

        // R7: offset layout, upper half masked, no kick while stopped
        cf_write(12'h008, 32'd20);
        cf_write(12'h00C, 32'hFFFF_0003);
        cf_check("R7 offset hi masked", 12'h00C, 32'h0000_0003);
        cf_check("R7 offset lo readback", 12'h008, 32'd20);
        cf_write(12'h00C, 32'h0);
        cf_check("R7 offset write stopped no kick", 12'h010, 32'h0);

        // R4: enable, control write is a kick
        cf_write(12'h000, 32'h1);
        cf_check("R4 enable reads back", 12'h000, 32'h1);
        cf_check_model("R4 kick loads compare lo", 12'h010);
        cf_check_model("R4 kick loads compare hi", 12'h014);

        // R2: first stage
        wait_stage(1'b0, 60, "R2 alert asserts");
        cf_check("R2 status shows alert", 12'h000, 32'h3);
        cf_check_model("R2 compare reloaded", 12'h010);

        // R5: other kick-port address ignored
        rf_write(12'h004);
        cf_check("R5 other kick address ignored", 12'h000, 32'h3);

        // R3: second stage
        wait_stage(1'b1, 60, "R3 reset request asserts");
        cf_check("R3 status shows both", 12'h000, 32'h7);

        // R5/R6: kick clears
        rf_write(12'h000);
        cf_check("R6 kick clears flags", 12'h000, 32'h1);
        cf_check_model("R6 kick reloads compare", 12'h010);

        // R6: kick wins over compare write in the same cycle
        @(negedge clk);
        cf_wr_en = 1'b1; cf_addr = 12'h010; cf_wdata = 32'h0;
        rf_wr_en = 1'b1; rf_addr = 12'h000;
        @(posedge clk); #1;
        cf_wr_en = 1'b0; rf_wr_en = 1'b0;
        cf_check_model("R6 kick beats compare write", 12'h010);
        cf_check("R6 no alert after collision", 12'h000, 32'h1);

        // R8: direct compare write, no kick, expires
        cf_write(12'h010, 32'h0);
        idle(2);
        cf_check("R8 compare write expires", 12'h000, 32'h3);

        // R10: stop, then compare in the past never fires
        cf_write(12'h000, 32'h0);
        cf_check("R4 stop clears all", 12'h000, 32'h0);
        cf_write(12'h010, 32'h0);
        idle(50);
        cf_check("R10 stopped stays quiet", 12'h000, 32'h0);

        // R7: offset write while enabled is a kick
        cf_write(12'h000, 32'h1);
        idle(5);
        cf_write(12'h008, 32'd30);
        cf_check_model("R7 offset write kicks when enabled", 12'h010);

        // R12: warm reset keeps reset request flag
        wait_stage(1'b1, 120, "R12 setup reset request");
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0;
        cf_check("R12 warm reset keeps flag", 12'h000, 32'h4);
        check("R12 ws1 output kept", {63'h0, ws1}, 64'h1);
        cf_check("R12 offset cleared", 12'h008, 32'h0);
        @(negedge clk); rst_por = 1'b1;
        idle(2);
        @(negedge clk); rst_por = 1'b0;
        cf_check("R1 por clears flag", 12'h000, 32'h0);

        // R7/R9: version 0 instance
        v0_write(12'h00C, 32'h0000_FFFF);
        v0_check("R7 v0 hi word reads zero", 12'h00C, 32'h0);
        v0_write(12'h008, 32'hFFFF_FFFF);
        v0_check("R7 v0 lo word", 12'h008, 32'hFFFF_FFFF);
        v0_check("R9 v0 ident", 12'hFCC, 32'h0);

        // random phase: R2 R3 R4 R5 R6 R8 R10 against the model
        cf_write(12'h008, 32'd12);
        cf_write(12'h000, 32'h1);
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            step = 64'($urandom_range(0, 3));
            case (op)
                0: rf_write(($urandom_range(0, 3) == 0) ? 12'h004 : 12'h000);
                1: cf_write(12'h000, {31'h0, ($urandom_range(0, 3) != 0)});
                2: cf_write(12'h008, 32'($urandom_range(1, 40)));
                3: cf_write(12'h010, sys_cnt[31:0] + 32'($urandom_range(0, 30)));
                4: begin
                    logic [11:0] a;
                    case ($urandom_range(0, 5))
                        0: a = 12'h000; 1: a = 12'h008; 2: a = 12'h00C;
                        3: a = 12'h010; 4: a = 12'h014; default: a = 12'hFCC;
                    endcase
                    cf_check_model("R6 random read", a);
                end
                default: idle(int'($urandom_range(1, 8)));
            endcase
        end
        step = 64'd1;
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule